// File: doc/BRIEF.md
# Mailbox Command Transaction Sequencer

This block runs one complete request/response exchange with a byte-wide mailbox peripheral on the host side. The peripheral is reached through a small byte bus with a one-bit address. Address 0 is the data port. Address 1 is the status port on reads and the command port on writes. The sequencer fetches the request bytes from a local buffer, one index at a time, and hands them over under a status-polled handshake. It then collects the framed response into a local response buffer and reports the 32-bit length field carried at the head of the response.

Every send opens with a defensive cancel and a drain-until-ready phase, because back-to-back commands can otherwise leave the peripheral stuck. The response is bounded by framing markers: a start marker 0x01 and an end marker 0x03. Each of these is read while a framing flag is raised. Every status wait samples once at once and then keeps polling up to a programmable limit. The ready wait has its own, usually much shorter, limit. Any failure ends the exchange with an error code and a one-cycle done pulse.

Top module: `mbx_seq`

## Requirements
- R1: An accepted start first writes the cancel code 0x22 to the command port (address 1).
- R2: The sequencer then reads status until the ready flag (bit 4) is seen. When a status read shows output-full (bit 0), the next cycle reads the data port, and that data byte, not the status byte, is tested for bit 4.
- R3: After ready, it waits for input-full (bit 1) to be clear, writes 0x01 to the command port, and then waits for input-ready (bit 5) to be set.
- R4: Before each request byte is written to the data port (address 0), and once more after the last byte, it waits for bit 1 to be clear. It then writes 0x03 to the command port. A request length of 0 goes straight to the final wait.
- R5: On receive it waits for the framing flag (bit 2), then reads the data port. A value other than 0x01 ends the exchange with code 6.
- R6: The payload loop waits for bit 0. If bit 2 is set in that same status byte, the loop ends. Otherwise one data byte is read and stored at the next buffer index. Once the buffer holds its capacity, the sequencer waits for bit 2 instead.
- R7: After the loop it reads the data port. A value other than 0x03 ends the exchange with code 7.
- R8: The reported length is the big-endian value of payload bytes 2 to 5. If that length exceeds the buffer capacity, the exchange ends with code 8.
- R9: A buffer capacity below 6 ends the exchange with code 9 in the next cycle, with no bus access.
- R10: With a limit L, a wait takes at most L+1 samples before it fails. The codes are: 1 for ready, 2 for input-full, 3 for input-ready, 4 for the framing flag, and 5 for output-full. Success is code 0.
- R11: Each exchange gives exactly one one-cycle done pulse, with the code and length held after it. A start seen while busy is ignored.
- R12: At most one bus access is made per cycle, none while idle, and only the accesses listed above occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an exchange when idle |
| req_len | input | IDX_W | Request byte count |
| req_idx | output | IDX_W | Request buffer read index |
| req_byte | input | 8 | Request byte at req_idx |
| rsp_cap | input | IDX_W | Response buffer capacity in bytes |
| rsp_we | output | 1 | Response buffer write strobe |
| rsp_idx | output | IDX_W | Response buffer write index |
| rsp_wdata | output | 8 | Response byte to store |
| ready_limit | input | TMO_W | Poll limit of the ready wait |
| stat_limit | input | TMO_W | Poll limit of all other waits |
| bus_rd | output | 1 | Mailbox read strobe, data sampled in the same cycle |
| bus_wr | output | 1 | Mailbox write strobe |
| bus_addr | output | 1 | 0 data port, 1 status/command port |
| bus_wdata | output | 8 | Mailbox write data |
| bus_rdata | input | 8 | Mailbox read data |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle end-of-exchange pulse |
| err | output | 4 | Result code, held after done |
| rsp_len | output | 32 | Length field of the response, held after done |

## Verification
Two functions can meet in one cycle, and both are provoked on purpose. The first pair is the end of the payload loop and the framing flag: a status byte with both output-full and the framing flag set must close the loop at once, with no extra data read. A buffer that fills exactly must instead fall through to a separate wait for the framing flag. The second pair is ready detection and draining: a status byte that shows both output-full and ready must trigger a drain read, and only the drained byte decides. A fresh start raised in the middle of an exchange must leave the bus sequence and the single done pulse unchanged. A bench model built from queues checks every bus access, cycle by cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [7:0] CMD_CANCEL = 8'h22;
  localparam logic [7:0] CMD_NORMAL = 8'h01;
  localparam logic [7:0] CMD_EOC    = 8'h03;
  localparam logic [7:0] MARK_OPEN  = 8'h01;
  localparam logic [7:0] MARK_CLOSE = 8'h03;

  // status bit positions
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_F0  = 2;
  localparam int ST_RDY = 4;
  localparam int ST_IBR = 5;

  localparam int MIN_CAP   = 6;
  localparam int LEN_FIRST = 2;
  localparam int LEN_BYTES = 4;

  typedef enum logic [3:0] {
    E_OK        = 4'd0,
    E_RDY_TMO   = 4'd1,
    E_IBF_TMO   = 4'd2,
    E_IBR_TMO   = 4'd3,
    E_F0_TMO    = 4'd4,
    E_OBF_TMO   = 4'd5,
    E_BAD_START = 4'd6,
    E_BAD_END   = 4'd7,
    E_LEN_OVER  = 4'd8,
    E_SMALL     = 4'd9
  } mbx_err_e;

  typedef enum logic [4:0] {
    S_IDLE, S_CANCEL, S_RDY, S_DRAIN, S_IBF0, S_NORM, S_IBR,
    S_TXW, S_TXD, S_TXEND, S_EOC, S_F0A, S_MARK0, S_OBF, S_RXD,
    S_F0B, S_MARK1
  } mbx_state_e;

  // true when a payload index falls inside the length field
  function automatic logic in_len_field(input int unsigned idx);
    return (idx >= LEN_FIRST) && (idx < LEN_FIRST + LEN_BYTES);
  endfunction

  // true when the announced length does not fit the buffer
  function automatic logic len_exceeds(input logic [31:0] len, input int unsigned cap);
    return len > cap;
  endfunction
endpackage

// File: rtl/mbx_wait_timer.sv
module mbx_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  assign expired = (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (step)   cnt_q <= cnt_q + 1'b1;
  end

  // R10: a miss only extends the wait while the budget is not used up
  p_step_below_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !expired);
endmodule

// File: rtl/mbx_len_grab.sv
module mbx_len_grab import mbx_pkg::*; #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  output logic [31:0]      len
);
  logic hit;
  assign hit = we && in_len_field(32'(idx));

  always_ff @(posedge clk) begin
    if (!rst_n)    len <= '0;
    else if (clr)  len <= '0;
    else if (hit)  len <= {len[23:0], data};
  end

  // R8: each length byte enters at the low end, earlier bytes move up
  p_len_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr) |=> (len[7:0] == $past(data)) && (len[31:8] == $past(len[23:0])));
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq import mbx_pkg::*; #(
  parameter  int MAX_BYTES = 16,
  parameter  int TMO_W     = 16,
  localparam int IDX_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] req_len,
  output logic [IDX_W-1:0] req_idx,
  input  logic [7:0]       req_byte,
  input  logic [IDX_W-1:0] rsp_cap,
  output logic             rsp_we,
  output logic [IDX_W-1:0] rsp_idx,
  output logic [7:0]       rsp_wdata,
  input  logic [TMO_W-1:0] ready_limit,
  input  logic [TMO_W-1:0] stat_limit,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic             bus_addr,
  output logic [7:0]       bus_wdata,
  input  logic [7:0]       bus_rdata,
  output logic             busy,
  output logic             done,
  output logic [3:0]       err,
  output logic [31:0]      rsp_len
);
  mbx_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d, idx_inc, txn_len_q, cap_q;
  logic             tmr_clr, tmr_step, tmr_exp;
  logic [TMO_W-1:0] tmr_lim;
  logic             wt_on, wt_ok;
  mbx_state_e       wt_nxt, wt_retry;
  mbx_err_e         wt_code;
  logic             fin;
  mbx_err_e         fin_code;
  logic             accept;
  logic [31:0]      cap_len;
  logic             done_q;
  mbx_err_e         err_q;
  logic [31:0]      len_q;

  assign accept  = (st_q == S_IDLE) && start;
  assign idx_inc = IDX_W'(idx_q + 1'b1);
  assign tmr_lim = (st_q == S_RDY || st_q == S_DRAIN) ? ready_limit : stat_limit;

  mbx_wait_timer #(.W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .step(tmr_step),
    .limit(tmr_lim), .expired(tmr_exp)
  );

  mbx_len_grab #(.IDX_W(IDX_W)) u_len (
    .clk(clk), .rst_n(rst_n), .clr(accept), .we(rsp_we),
    .idx(idx_q), .data(bus_rdata), .len(cap_len)
  );

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    bus_rd    = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = 1'b0;
    bus_wdata = 8'h00;
    rsp_we    = 1'b0;
    tmr_clr   = 1'b0;
    tmr_step  = 1'b0;
    wt_on     = 1'b0;
    wt_ok     = 1'b0;
    wt_nxt    = st_q;
    wt_retry  = st_q;
    wt_code   = E_OK;
    fin       = 1'b0;
    fin_code  = E_OK;
    case (st_q)
      S_IDLE: if (start) begin
        if (rsp_cap < IDX_W'(MIN_CAP)) begin
          fin = 1'b1; fin_code = E_SMALL;
        end else begin
          st_d = S_CANCEL; idx_d = '0; tmr_clr = 1'b1;
        end
      end
      S_CANCEL: begin
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = CMD_CANCEL; st_d = S_RDY;
      end
      S_RDY: begin
        bus_rd = 1'b1; bus_addr = 1'b1;
        if (bus_rdata[ST_OBF]) st_d = S_DRAIN;
        else begin
          wt_on = 1'b1; wt_ok = bus_rdata[ST_RDY]; wt_code = E_RDY_TMO; wt_nxt = S_IBF0;
        end
      end
      S_DRAIN: begin
        bus_rd = 1'b1;
        wt_on = 1'b1; wt_ok = bus_rdata[ST_RDY]; wt_code = E_RDY_TMO;
        wt_nxt = S_IBF0; wt_retry = S_RDY;
      end
      S_IBF0: begin
        bus_rd = 1'b1; bus_addr = 1'b1;
        wt_on = 1'b1; wt_ok = !bus_rdata[ST_IBF]; wt_code = E_IBF_TMO; wt_nxt = S_NORM;
      end
      S_NORM: begin
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = CMD_NORMAL; st_d = S_IBR;
      end
      S_IBR: begin
        bus_rd = 1'b1; bus_addr = 1'b1;
        wt_on = 1'b1; wt_ok = bus_rdata[ST_IBR]; wt_code = E_IBR_TMO;
        wt_nxt = (txn_len_q == '0) ? S_TXEND : S_TXW;
      end
      S_TXW: begin
        bus_rd = 1'b1; bus_addr = 1'b1;
        wt_on = 1'b1; wt_ok = !bus_rdata[ST_IBF]; wt_code = E_IBF_TMO; wt_nxt = S_TXD;
      end
      S_TXD: begin
        bus_wr = 1'b1; bus_wdata = req_byte; idx_d = idx_inc;
        st_d = (idx_inc == txn_len_q) ? S_TXEND : S_TXW;
      end
      S_TXEND: begin
        bus_rd = 1'b1; bus_addr = 1'b1;
        wt_on = 1'b1; wt_ok = !bus_rdata[ST_IBF]; wt_code = E_IBF_TMO; wt_nxt = S_EOC;
      end
      S_EOC: begin
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = CMD_EOC; idx_d = '0; st_d = S_F0A;
      end
      S_F0A: begin
        bus_rd = 1'b1; bus_addr = 1'b1;
        wt_on = 1'b1; wt_ok = bus_rdata[ST_F0]; wt_code = E_F0_TMO; wt_nxt = S_MARK0;
      end
      S_MARK0: begin
        bus_rd = 1'b1;
        if (bus_rdata != MARK_OPEN) begin
          fin = 1'b1; fin_code = E_BAD_START;
        end else st_d = S_OBF;
      end
      S_OBF: begin
        bus_rd = 1'b1; bus_addr = 1'b1;
        wt_on = 1'b1; wt_ok = bus_rdata[ST_OBF]; wt_code = E_OBF_TMO;
        wt_nxt = bus_rdata[ST_F0] ? S_MARK1 : S_RXD;
      end
      S_RXD: begin
        bus_rd = 1'b1; rsp_we = 1'b1; idx_d = idx_inc;
        st_d = (idx_inc == cap_q) ? S_F0B : S_OBF;
      end
      S_F0B: begin
        bus_rd = 1'b1; bus_addr = 1'b1;
        wt_on = 1'b1; wt_ok = bus_rdata[ST_F0]; wt_code = E_F0_TMO; wt_nxt = S_MARK1;
      end
      S_MARK1: begin
        bus_rd = 1'b1; fin = 1'b1;
        if (bus_rdata != MARK_CLOSE)                  fin_code = E_BAD_END;
        else if (len_exceeds(cap_len, 32'(cap_q)))    fin_code = E_LEN_OVER;
        else                                          fin_code = E_OK;
      end
      default: st_d = S_IDLE;
    endcase

    if (wt_on) begin
      if (wt_ok) begin
        st_d = wt_nxt; tmr_clr = 1'b1;
      end else if (tmr_exp) begin
        fin = 1'b1; fin_code = wt_code;
      end else begin
        tmr_step = 1'b1; st_d = wt_retry;
      end
    end

    if (fin) begin
      st_d = S_IDLE; tmr_clr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      idx_q     <= '0;
      txn_len_q <= '0;
      cap_q     <= '0;
      done_q    <= 1'b0;
      err_q     <= E_OK;
      len_q     <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      done_q <= fin;
      if (accept) begin
        txn_len_q <= req_len;
        cap_q     <= rsp_cap;
      end
      if (fin) begin
        err_q <= fin_code;
        len_q <= (st_q == S_IDLE) ? '0 : cap_len;
      end
    end
  end

  assign req_idx   = idx_q;
  assign rsp_idx   = idx_q;
  assign rsp_wdata = bus_rdata;
  assign busy      = (st_q != S_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign rsp_len   = len_q;

  // R1: the first access of an exchange is the cancel command
  p_cancel_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bus_wr && bus_addr && bus_wdata == CMD_CANCEL));

  // R6: stores never run past the captured capacity
  p_store_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_we |-> (rsp_idx < cap_q));

  // R8: a clean finish never reports a length beyond the buffer
  p_ok_len_fits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == E_OK) |-> (rsp_len <= 32'(cap_q)));

  // R9: the small-buffer result comes straight from idle
  p_small_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == E_SMALL) |-> $past(!busy));

  // R11: done lasts one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12: one access at a time and none while idle
  p_single_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(bus_rd || bus_wr));
endmodule

// File: tb/test_mbx_seq.sv
module test_mbx_seq;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst_n, start;
  logic [IW-1:0] req_len, req_idx, rsp_cap, rsp_idx;
  logic [7:0]    req_byte, rsp_wdata, bus_wdata, bus_rdata;
  logic          rsp_we, bus_rd, bus_wr, bus_addr, busy, done;
  logic [15:0]   ready_limit, stat_limit;
  logic [3:0]    err;
  logic [31:0]   rsp_len;

  logic [7:0] reqm [0:15];
  logic [7:0] pay  [0:15];
  logic [7:0] rmem [0:15];

  int qw[$], qa[$], qd[$];
  int consume = 0;
  int nchk = 0, nerr = 0, ndone = 0, nrx = 0;
  int got_err = 0, got_len = 0;

  always #10 clk = ~clk;

  mbx_seq i_mbx_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .req_len(req_len), .req_idx(req_idx),
    .req_byte(req_byte), .rsp_cap(rsp_cap), .rsp_we(rsp_we), .rsp_idx(rsp_idx),
    .rsp_wdata(rsp_wdata), .ready_limit(ready_limit), .stat_limit(stat_limit),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .err(err), .rsp_len(rsp_len)
  );

  always_comb req_byte = (req_idx < 16) ? reqm[req_idx[3:0]] : 8'h00;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference model: queue of expected accesses, compared every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_rd || bus_wr) begin
        if (qw.size() == 0)
          chk(1'b0, "R12 unexpected access", {22'd0, bus_wr, bus_addr, bus_wdata}, 0);
        else begin
          chk(bus_wr == qw[0][0] && bus_addr == qa[0][0] && (!bus_wr || bus_wdata == qd[0][7:0]),
              "R12 access order",
              bus_wr ? (512 + 256 * bus_addr + bus_wdata) : 256 * bus_addr,
              qw[0] ? (512 + 256 * qa[0] + qd[0]) : 256 * qa[0]);
          consume = 1;
        end
      end
      if (done) begin
        ndone++;
        got_err = int'(err);
        got_len = int'(rsp_len);
      end
      if (rsp_we) begin
        rmem[rsp_idx[3:0]] = rsp_wdata;
        nrx++;
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (consume != 0) begin
      void'(qw.pop_front()); void'(qa.pop_front()); void'(qd.pop_front());
      consume = 0;
    end
    bus_rdata = (qw.size() != 0) ? qd[0][7:0] : 8'h00;
  end

  task automatic push(input int w, input int a, input int d);
    qw.push_back(w); qa.push_back(a); qd.push_back(d);
  endtask

  task automatic poll(input int m, input int miss, input int hit);
    repeat (m) push(0, 1, miss);
    push(0, 1, hit);
  endtask

  task automatic misses(input int m, input int v);
    repeat (m) push(0, 1, v);
  endtask

  task automatic send_std(input int n, input int m);
    push(1, 1, 'h22);
    poll(m, 'h00, 'h10);
    poll(m, 'h02, 'h00);
    push(1, 1, 'h01);
    poll(m, 'h00, 'h20);
    for (int i = 0; i < n; i++) begin
      poll(m, 'h02, 'h00);
      push(1, 0, int'(reqm[i]));
    end
    poll(m, 'h02, 'h00);
    push(1, 1, 'h03);
  endtask

  task automatic recv_std(input int n, input int m, input int full, input int endm);
    poll(m, 'h00, 'h04);
    push(0, 0, 'h01);
    for (int i = 0; i < n; i++) begin
      poll(m, 'h00, 'h01);
      push(0, 0, int'(pay[i]));
    end
    if (full != 0) poll(m, 'h01, 'h04);
    else           poll(0, 'h00, 'h05);
    push(0, 0, endm);
  endtask

  task automatic hdr(input int len);
    for (int i = 0; i < 16; i++) pay[i] = 8'(8'h30 + i);
    pay[0] = 8'h00; pay[1] = 8'hC4;
    pay[2] = len[31:24]; pay[3] = len[23:16]; pay[4] = len[15:8]; pay[5] = len[7:0];
  endtask

  task automatic run(input string tag, input int exp_err, input int exp_len,
                     input int n_rx, input int poke);
    ndone = 0; nrx = 0;
    @(negedge clk); #1; start = 1'b1;
    @(negedge clk); #1; start = 1'b0;
    for (int c = 0; c < 4000; c++) begin
      if (ndone != 0) break;
      if (c == poke) start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(ndone == 1, "R11 single done pulse", ndone, 1);
    chk(got_err == exp_err, tag, got_err, exp_err);
    if (exp_len >= 0) chk(got_len == exp_len, "R8 reported length", got_len, exp_len);
    chk(qw.size() == 0, "R12 accesses left over", qw.size(), 0);
    chk(nrx == n_rx, "R6 stored byte count", nrx, n_rx);
    for (int i = 0; i < n_rx && i < 16; i++)
      chk(rmem[i] == pay[i], "R6 stored payload byte", int'(rmem[i]), int'(pay[i]));
    chk(busy == 1'b0, "R11 idle after done", int'(busy), 0);
  endtask

  initial begin
    #(20 * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) reqm[i] = 8'(8'hA0 + i);
    for (int i = 0; i < 16; i++) rmem[i] = 8'h00;
    hdr(0);
    rst_n = 1'b0; start = 1'b0; req_len = '0; rsp_cap = 5'd16;
    ready_limit = 16'd4; stat_limit = 16'd8; bus_rdata = 8'h00;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && err == 4'd0, "R11 reset state",
        {busy, done, err}, 0);
    chk(!bus_rd && !bus_wr, "R12 quiet in reset", {bus_rd, bus_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R4 R5 R6 R7 R8: full exchange with misses, extra start mid-way
    req_len = 5'd3; rsp_cap = 5'd16; hdr(10);
    send_std(3, 1); recv_std(10, 1, 0, 'h03);
    run("R7 clean exchange code", 0, 10, 10, 6);

    // R2: drain with output-full; status ready ignored, data byte decides; R6 exact fill
    req_len = 5'd0; rsp_cap = 5'd6; hdr(6);
    push(1, 1, 'h22);
    push(0, 1, 'h01); push(0, 0, 'h00);
    push(0, 1, 'h11); push(0, 0, 'h10);
    poll(0, 0, 'h00); push(1, 1, 'h01); poll(0, 0, 'h20);
    poll(0, 0, 'h00); push(1, 1, 'h03);
    recv_std(6, 0, 1, 'h03);
    run("R2 drain then ready code", 0, 6, 6, -1);

    // R5: bad start marker
    req_len = 5'd1; rsp_cap = 5'd16;
    send_std(1, 0); poll(0, 0, 'h04); push(0, 0, 'h02);
    run("R5 bad start code", 6, -1, 0, -1);

    // R7: bad end marker
    hdr(6);
    send_std(1, 0); recv_std(6, 0, 0, 'h07);
    run("R7 bad end code", 7, -1, 6, -1);

    // R8: length beyond capacity
    req_len = 5'd2; rsp_cap = 5'd8; hdr(256);
    send_std(2, 0); recv_std(7, 0, 0, 'h03);
    run("R8 length overflow code", 8, 256, 7, -1);

    // R10: ready timeout after limit+1 samples
    ready_limit = 16'd2; rsp_cap = 5'd16;
    push(1, 1, 'h22); misses(3, 'h00);
    run("R10 ready timeout code", 1, -1, 0, -1);
    ready_limit = 16'd4;

    // R10 R3: input-ready timeout
    stat_limit = 16'd3;
    push(1, 1, 'h22); poll(0, 0, 'h10); poll(0, 0, 'h00); push(1, 1, 'h01);
    misses(4, 'h00);
    run("R10 input-ready timeout code", 3, -1, 0, -1);

    // R10 R4: input-full timeout while writing data
    stat_limit = 16'd1; req_len = 5'd2;
    push(1, 1, 'h22); poll(0, 0, 'h10); poll(0, 0, 'h00); push(1, 1, 'h01);
    poll(0, 0, 'h20); misses(2, 'h02);
    run("R10 input-full timeout code", 2, -1, 0, -1);

    // R10 R6: output-full timeout in payload loop
    stat_limit = 16'd2; req_len = 5'd1;
    send_std(1, 0); poll(0, 0, 'h04); push(0, 0, 'h01); misses(3, 'h00);
    run("R10 output-full timeout code", 5, -1, 0, -1);

    // R10 R6: framing-flag timeout after the buffer filled
    stat_limit = 16'd1; rsp_cap = 5'd6; hdr(6);
    send_std(1, 0); poll(0, 0, 'h04); push(0, 0, 'h01);
    for (int i = 0; i < 6; i++) begin poll(0, 0, 'h01); push(0, 0, int'(pay[i])); end
    misses(2, 'h01);
    run("R10 framing timeout code", 4, -1, 6, -1);

    // R9: small buffer, no bus access
    rsp_cap = 5'd5;
    run("R9 small buffer code", 9, 0, 0, -1);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule